// File: doc/BRIEF.md
# Data-strobe character receiver decoder

This block sits at the receive end of a serial data/strobe link. Both line inputs are first brought into the system clock domain. A change on either line marks one received bit, and the bit's value is the level of the data line. This takes the place of a clock built from the XOR of the two lines: each change of that XOR is exactly one change of D or S.

The block starts out unaligned. It searches the bit stream one bit at a time for the NULL pattern. Once it finds it, it frames characters by their flag bit: a flag of 0 means a 10-bit data character and a flag of 1 means a 4-bit control character. It checks odd parity and decodes the escape sequences.

Data bytes and packet end marks go out as 9-bit receive FIFO writes. FCT, NULL and time-code arrivals are reported as single-cycle pulses. A sticky error flag stops all decoding until reset.

Top module: `ds_char_decoder`

## Requirements
- R1: Each change of the synchronised D/S pair is one received bit whose value is the new D level. While both lines are steady, no bit is received and no output event occurs.
- R2: Before alignment, no event other than NULL is reported. The block finds the NULL sequence at any bit offset. In transmit order that sequence is: any bit, then 1,1,1, then 0,1,0,0. On finding it, `null_seen` rises in the same cycle as a `got_null` pulse and stays high until reset.
- R3: A character is sent parity bit first, then flag bit. With flag 0 it carries 8 data bits, LSB first. It produces one FIFO write with bit 8 = 0 and the byte in bits 7:0.
- R4: With flag 1, the two following code bits in transmit order select FCT (0,0), EOP (0,1), EEP (1,0) or ESC (1,1). An FCT not preceded by ESC gives one `got_fct` pulse.
- R5: EOP is written to the FIFO as 9'h100 and EEP as 9'h101.
- R6: ESC followed by FCT gives one `got_null` pulse. ESC followed by a data character gives one `tc_valid` pulse with `tc_data` holding that byte. Neither of these writes the FIFO.
- R7: The parity is checked on each character. The payload bits of the previous character, plus the current parity bit and the current flag bit, must hold an odd number of ones. After alignment, the previous character is the aligning FCT, with payload 0,0. A mismatch sets `par_err` and `err`, and the character produces no event.
- R8: ESC followed by ESC, EOP or EEP sets `err` and leaves `par_err` at 0. It produces no event.
- R9: Reset clears all outputs, `null_seen`, `err` and `par_err`. After `err` is set, no further event is reported until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ds_d | input | 1 | Data line of the serial pair |
| ds_s | input | 1 | Strobe line of the serial pair |
| fifo_wr | output | 1 | Receive FIFO write pulse |
| fifo_data | output | 9 | FIFO entry: bit 8 marks an end of packet, bits 7:0 are the byte or end code |
| got_fct | output | 1 | Pulse on a received FCT |
| got_null | output | 1 | Pulse on a received NULL |
| null_seen | output | 1 | High from the first NULL until reset |
| tc_valid | output | 1 | Pulse on a received time code |
| tc_data | output | 8 | Time-code byte |
| par_err | output | 1 | Sticky parity error |
| err | output | 1 | Sticky error: parity or illegal escape sequence |

## Verification
The assertions take for granted that only one of D and S changes per bit period. They also assume that successive changes are spaced further apart than the synchroniser depth, so every bit is seen exactly once. The stimulus meets this by driving a bit every four clocks and, for each bit, toggling either D (when its value differs from the last bit) or S (when it is the same). Under that assumption, events are mutually exclusive per cycle and nothing is reported before alignment or after an error.

// File: rtl/ds_char_decoder.sv
module ds_char_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_LEN    = 10,
  parameter int CTRL_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ds_d,
  input  logic       ds_s,
  output logic       fifo_wr,
  output logic [8:0] fifo_data,
  output logic       got_fct,
  output logic       got_null,
  output logic       null_seen,
  output logic       tc_valid,
  output logic [7:0] tc_data,
  output logic       par_err,
  output logic       err
);
  localparam int CW = $clog2(DATA_LEN + 1);

  logic [SYNC_STAGES:0] d_sr, s_sr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_sr <= '0;
      s_sr <= '0;
    end else begin
      d_sr <= {d_sr[SYNC_STAGES-1:0], ds_d};
      s_sr <= {s_sr[SYNC_STAGES-1:0], ds_s};
    end
  end

  wire bit_vld = (d_sr[SYNC_STAGES-1] ^ d_sr[SYNC_STAGES]) |
                 (s_sr[SYNC_STAGES-1] ^ s_sr[SYNC_STAGES]);
  wire bit_in  = d_sr[SYNC_STAGES-1];

  logic [5:0]          win;
  logic                aligned, prev_par, esc;
  logic [CW-1:0]       cnt;
  logic [DATA_LEN-1:0] chr, cur;

  always_comb
    for (int i = 0; i < DATA_LEN; i++)
      cur[i] = (CW'(i) == cnt) ? bit_in : chr[i];

  wire       is_ctrl  = cur[1];
  wire [1:0] code     = {cur[2], cur[3]};
  wire       done     = bit_vld && aligned && !err &&
                        ((cnt == CW'(CTRL_LEN - 1) && is_ctrl) || cnt == CW'(DATA_LEN - 1));
  wire       par_ok   = prev_par ^ cur[0] ^ cur[1];
  wire       esc_bad  = esc && is_ctrl && code != 2'b00;
  wire       null_hit = {win, bit_in} == 7'b1110100;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0; aligned <= 1'b0; prev_par <= 1'b0; esc <= 1'b0;
      cnt <= '0; chr <= '0;
      fifo_wr <= 1'b0; fifo_data <= '0; got_fct <= 1'b0; got_null <= 1'b0;
      null_seen <= 1'b0; tc_valid <= 1'b0; tc_data <= '0;
      par_err <= 1'b0; err <= 1'b0;
    end else begin
      fifo_wr  <= 1'b0;
      got_fct  <= 1'b0;
      got_null <= 1'b0;
      tc_valid <= 1'b0;
      if (bit_vld && !err) begin
        if (!aligned) begin
          win <= {win[4:0], bit_in};
          if (null_hit) begin
            aligned   <= 1'b1;
            null_seen <= 1'b1;
            got_null  <= 1'b1;
            prev_par  <= 1'b0;
            cnt       <= '0;
            chr       <= '0;
          end
        end else if (done) begin
          cnt      <= '0;
          chr      <= '0;
          prev_par <= is_ctrl ? ^cur[3:2] : ^cur[DATA_LEN-1:2];
          if (!par_ok || esc_bad) begin
            err     <= 1'b1;
            par_err <= !par_ok;
          end else if (!is_ctrl) begin
            if (esc) begin
              tc_valid <= 1'b1;
              tc_data  <= cur[9:2];
              esc      <= 1'b0;
            end else begin
              fifo_wr   <= 1'b1;
              fifo_data <= {1'b0, cur[9:2]};
            end
          end else begin
            case (code)
              2'b00: if (esc) begin got_null <= 1'b1; esc <= 1'b0; end
                     else got_fct <= 1'b1;
              2'b01: begin fifo_wr <= 1'b1; fifo_data <= 9'h100; end
              2'b10: begin fifo_wr <= 1'b1; fifo_data <= 9'h101; end
              default: esc <= 1'b1;
            endcase
          end
        end else begin
          chr <= cur;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, got_fct, got_null, tc_valid}));
  a_r2_nothing_before_null: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr || got_fct || tc_valid) |-> null_seen);
  a_r2_first_null: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(null_seen) |-> got_null);
  a_r2_null_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    null_seen |=> null_seen);
  a_r5_end_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_data[8]) |-> fifo_data[7:1] == 7'd0);
  a_r7_par_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> err);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r9_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !(fifo_wr || got_fct || got_null || tc_valid));
endmodule

// File: tb/test_ds_char_decoder.sv
module test_ds_char_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, d_line, s_line;
  logic fifo_wr, got_fct, got_null, null_seen, tc_valid, par_err, err;
  logic [8:0] fifo_data;
  logic [7:0] tc_data;

  ds_char_decoder i_ds_char_decoder (
    .clk(clk), .rst_n(rst_n), .ds_d(d_line), .ds_s(s_line),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .got_fct(got_fct),
    .got_null(got_null), .null_seen(null_seen), .tc_valid(tc_valid),
    .tc_data(tc_data), .par_err(par_err), .err(err));

  int checks = 0, fails = 0, ev_cnt = 0;
  logic [11:0] ev_last = '0;
  bit tx_par = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (fifo_wr)  begin ev_cnt++; ev_last = {3'd1, fifo_data}; end
    if (got_fct)  begin ev_cnt++; ev_last = {3'd2, 9'd0}; end
    if (got_null) begin ev_cnt++; ev_last = {3'd3, 9'd0}; end
    if (tc_valid) begin ev_cnt++; ev_last = {3'd4, 1'b0, tc_data}; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    if (b == d_line) s_line = ~s_line;
    else d_line = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_ctrl(input bit c0, input bit c1, input bit bad);
    send_bit(tx_par ^ bad); send_bit(1'b1); send_bit(c0); send_bit(c1);
    tx_par = c0 ^ c1;
  endtask

  task automatic send_data(input logic [7:0] v, input bit bad);
    send_bit(~tx_par ^ bad); send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    tx_par = ^v;
  endtask

  task automatic settle;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; d_line = 1'b0; s_line = 1'b0; tx_par = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    ev_cnt = 0;
  endtask

  task automatic hunt(input logic [3:0] junk, input int n);
    for (int i = 0; i < n; i++) send_bit(junk[i]);
    tx_par = 1'b0;
    send_ctrl(1'b1, 1'b1, 1'b0);
    send_ctrl(1'b0, 1'b0, 1'b0);
    settle();
    ev_cnt = 0;
  endtask

  task automatic send_stim(input logic [2:0] st, input logic [7:0] v);
    case (st)
      3'd0: send_data(v, 1'b0);
      3'd1: send_ctrl(1'b0, 1'b0, 1'b0);
      3'd2: send_ctrl(1'b0, 1'b1, 1'b0);
      3'd3: send_ctrl(1'b1, 1'b0, 1'b0);
      3'd4: begin send_ctrl(1'b1, 1'b1, 1'b0); send_ctrl(1'b0, 1'b0, 1'b0); end
      default: begin send_ctrl(1'b1, 1'b1, 1'b0); send_data(v, 1'b0); end
    endcase
  endtask

  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 8'hA5, 3'd1, 9'h0A5},  // R3
    {3'd0, 8'h00, 3'd1, 9'h000},  // R3 R1 strobe-only bits
    {3'd0, 8'hFF, 3'd1, 9'h0FF},  // R3 R7
    {3'd1, 8'h00, 3'd2, 9'h000},  // R4
    {3'd2, 8'h00, 3'd1, 9'h100},  // R5
    {3'd0, 8'h80, 3'd1, 9'h080},  // R3
    {3'd3, 8'h00, 3'd1, 9'h101},  // R5
    {3'd4, 8'h00, 3'd3, 9'h000},  // R6
    {3'd5, 8'h3C, 3'd4, 9'h03C},  // R6
    {3'd0, 8'h01, 3'd1, 9'h001},  // R3 R7
    {3'd5, 8'hC1, 3'd4, 9'h0C1}   // R6
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    settle();
    check("R9 reset outputs", {fifo_wr, got_fct, got_null, tc_valid, null_seen, par_err, err}, 0);

    send_data(8'h5A, 1'b0);
    settle();
    check("R2 no event before alignment", ev_cnt, 0);
    check("R2 null_seen low before NULL", null_seen, 0);
    send_bit(1'b1); send_bit(1'b0);
    tx_par = 1'b0;
    send_ctrl(1'b1, 1'b1, 1'b0);
    send_ctrl(1'b0, 1'b0, 1'b0);
    settle();
    check("R2 NULL event count", ev_cnt, 1);
    check("R2 NULL event", ev_last, {3'd3, 9'd0});
    check("R2 null_seen high", null_seen, 1);

    for (int k = 0; k < NV; k++) begin
      ev_cnt = 0;
      send_stim(VEC[k][22:20], VEC[k][19:12]);
      settle();
      check($sformatf("vector %0d count (R3-R6 table)", k), ev_cnt, 1);
      check($sformatf("vector %0d event (R3-R6 table)", k), ev_last, VEC[k][11:0]);
    end

    ev_cnt = 0;
    repeat (60) @(negedge clk);
    check("R1 idle lines give no event", ev_cnt, 0);

    send_data(8'h33, 1'b1);
    settle();
    check("R7 bad parity no event", ev_cnt, 0);
    check("R7 par_err set", par_err, 1);
    check("R7 err set", err, 1);
    send_data(8'h44, 1'b0);
    send_ctrl(1'b0, 1'b0, 1'b0);
    settle();
    check("R9 frozen after error", ev_cnt, 0);

    do_reset();
    settle();
    check("R9 reset clears err", {err, par_err, null_seen}, 0);
    hunt(4'b0000, 1);
    send_ctrl(1'b0, 1'b0, 1'b1);
    settle();
    check("R7 control parity error", {par_err, err}, 2'b11);
    check("R7 control parity no event", ev_cnt, 0);

    do_reset();
    hunt(4'b0101, 3);
    send_ctrl(1'b1, 1'b1, 1'b0);
    send_ctrl(1'b0, 1'b1, 1'b0);
    settle();
    check("R8 ESC EOP error", {par_err, err}, 2'b01);
    check("R8 ESC EOP no write", ev_cnt, 0);

    do_reset();
    hunt(4'b0011, 2);
    send_ctrl(1'b1, 1'b1, 1'b0);
    send_ctrl(1'b1, 1'b1, 1'b0);
    settle();
    check("R8 ESC ESC error", {par_err, err}, 2'b01);

    do_reset();
    hunt(4'b0000, 0);
    send_ctrl(1'b1, 1'b1, 1'b0);
    send_ctrl(1'b1, 1'b0, 1'b0);
    settle();
    check("R8 ESC EEP error", {par_err, err}, 2'b01);
    check("R8 ESC EEP no write", ev_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule